// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This unit shifts or rotates a byte, word or long operand by a count of bit positions, one position per two clocks. It has eight operations: arithmetic shift, logical shift, plain rotate and rotate through an extend bit, each to the left or to the right. A request is accepted on a clock edge where `start_i` is high and the unit is idle. The unit then spends a fixed setup time that depends on the operand size, followed by two clocks for each bit position. It raises `done_o` for one cycle when `result_o`, `carry_o` and `xflag_o` are final. These outputs hold until the next request is accepted.

A second form, selected by `mem_i`, shifts a byte or word operand by exactly one position in a fixed time and ignores the count. A long request in this form is refused with a one-cycle `reject_o` pulse. Bits of the operand above the selected size are passed through to the result unchanged.

The sequencer has four states: IDLE (waiting for a request), PREP (the setup time), STEP (two clocks per bit, with the shift on the second clock) and DONE (the completion cycle). The transitions are:
- IDLE to PREP on an accepted request.
- PREP to STEP when the setup count is exhausted and bits remain, or PREP to DONE when the count is zero.
- STEP to DONE on the second clock of the last bit.
- DONE to IDLE unconditionally.

Top module: `shift_rotate_engine`

## Requirements
- R1: With `mem_i`=0 and a byte (`size_i`=00) or word (`size_i`=01) operand, `done_o` goes high 6+2n clock edges after the accepting edge, for exactly one cycle, where n is the effective count.
- R2: With `mem_i`=0 and a long operand (`size_i`=10 or 11), `done_o` goes high 8+2n edges after the accepting edge.
- R3: With `mem_i`=1 and a byte or word operand, the operand is shifted by exactly one position whatever `count_i` holds, and `done_o` goes high 8 edges after the accepting edge.
- R4: With `mem_i`=1 and a long size, the request is refused. `reject_o` is high for one cycle after the edge, `busy_o` and `done_o` stay low, and `result_o` keeps its previous value.
- R5: Left arithmetic (`op_i`=00) and left logical (`op_i`=01) shifts, with `left_i`=1, move bits toward the top bit of the selected size and fill the bottom bit with 0. The bit shifted out is the top bit of the size.
- R6: With `left_i`=0, an arithmetic right shift copies the sign bit of the selected size into the vacated top bit, and a logical right shift fills that bit with 0.
- R7: A plain rotate (`op_i`=10) moves the bit that leaves one end of the size into the other end. It leaves `xflag_o` equal to the `x_i` that was sampled at acceptance.
- R8: A rotate through extend (`op_i`=11) rotates size+1 bits, with the extend bit placed next to the top of the size. After it completes, `carry_o` equals `xflag_o`.
- R9: For n>0, `carry_o` is the last bit shifted out, and `xflag_o` equals it for all operations except the plain rotate. For n=0, `xflag_o` equals `x_i`, and `carry_o` is 0, except in a rotate through extend, where it equals `x_i`.
- R10: The result bits above the selected size equal the operand bits in those positions.
- R11: In the register form, the effective count is `count_i` modulo 64.
- R12: `busy_o` is high from the accepting edge until `done_o` rises. A `start_i` seen while busy or during the done cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled in IDLE |
| mem_i | input | 1 | 1 selects the one-bit fixed-time form |
| size_i | input | 2 | 00 byte, 01 word, 1x long |
| op_i | input | 2 | 00 arithmetic, 01 logical, 10 rotate, 11 rotate through extend |
| left_i | input | 1 | 1 shifts left, 0 shifts right |
| count_i | input | CNT_IN_W | Shift count (low six bits used) |
| x_i | input | 1 | Extend bit at request time |
| operand_i | input | 32 | Operand |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Carry bit |
| xflag_o | output | 1 | Extend bit after the operation |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |
| reject_o | output | 1 | One-cycle refusal of a long request in the one-bit form |

## Verification
The assertions check every cycle that:
- `done_o` never lasts two cycles.
- A refusal never coincides with activity.
- STEP is never entered with no bits left.
- A plain rotate never disturbs the extend bit.
- A byte operation never alters bits above bit 7.
- A rotate through extend finishes with carry equal to extend.

Only the bench scenarios can show the exact latencies, the fill and wrap-around values of each operation, the modulo-64 count, and that requests arriving during a busy period or the done cycle are dropped.

// File: rtl/sre_pkg.sv
package sre_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        OP_ARITH = 2'd0,
        OP_LOGIC = 2'd1,
        OP_ROT   = 2'd2,
        OP_ROTX  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_STEP = 2'd2,
        ST_DONE = 2'd3
    } state_e;
endpackage

// File: rtl/sre_req_decode.sv
module sre_req_decode
    import sre_pkg::*;
#(
    parameter int CNT_IN_W   = 8,
    parameter int BASE_SHORT = 6,
    parameter int BASE_LONG  = 8,
    parameter int MEM_TOTAL  = 8,
    parameter int WAIT_W     = 4
) (
    input  logic [1:0]          size_i,
    input  logic                mem_i,
    input  logic [CNT_IN_W-1:0] count_i,
    output size_e               sz_o,
    output logic                reject_o,
    output logic [CNT_W-1:0]    steps_o,
    output logic [WAIT_W-1:0]   wait_o
);
    always_comb begin
        if (size_i[1]) begin
            sz_o = SZ_LONG;
        end else if (size_i[0]) begin
            sz_o = SZ_WORD;
        end else begin
            sz_o = SZ_BYTE;
        end

        reject_o = mem_i && (sz_o == SZ_LONG);

        if (mem_i) begin
            // one bit takes two clocks of the fixed total
            steps_o = CNT_W'(1);
            wait_o  = WAIT_W'(MEM_TOTAL - 3);
        end else begin
            steps_o = count_i[CNT_W-1:0];
            wait_o  = (sz_o == SZ_LONG) ? WAIT_W'(BASE_LONG - 1)
                                        : WAIT_W'(BASE_SHORT - 1);
        end
    end
endmodule

// File: rtl/sre_fsm.sv
module sre_fsm
    import sre_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              reject_i,
    input  logic [CNT_W-1:0]  steps_i,
    input  logic [WAIT_W-1:0] wait_i,
    output logic              load_o,
    output logic              shift_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              reject_o
);
    state_e            state, state_n;
    logic [WAIT_W-1:0] wait_cnt;
    logic [CNT_W-1:0]  bits_left;
    logic              phase;
    logic              rej_q;
    logic              accept;

    assign accept = (state == ST_IDLE) && start_i && !reject_i;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (accept) state_n = ST_PREP;
            ST_PREP: if (wait_cnt == '0) state_n = (bits_left != '0) ? ST_STEP : ST_DONE;
            ST_STEP: if (phase && bits_left == CNT_W'(1)) state_n = ST_DONE;
            ST_DONE: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            wait_cnt  <= '0;
            bits_left <= '0;
            phase     <= 1'b0;
            rej_q     <= 1'b0;
        end else begin
            state <= state_n;
            rej_q <= (state == ST_IDLE) && start_i && reject_i;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        wait_cnt  <= wait_i;
                        bits_left <= steps_i;
                        phase     <= 1'b0;
                    end
                end
                ST_PREP: begin
                    if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
                end
                ST_STEP: begin
                    phase <= ~phase;
                    if (phase) bits_left <= bits_left - 1'b1;
                end
                ST_DONE: ;
            endcase
        end
    end

    always_comb begin
        load_o   = accept;
        shift_o  = (state == ST_STEP) && phase;
        busy_o   = (state == ST_PREP) || (state == ST_STEP);
        done_o   = (state == ST_DONE);
        reject_o = rej_q;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R1
    AST_STEP_HAS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP) |-> (bits_left != '0)); // R2
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> (!busy_o && !done_o)); // R4
endmodule

// File: rtl/sre_bit_step.sv
module sre_bit_step
    import sre_pkg::*;
(
    input  logic [DATA_W-1:0] acc_i,
    input  size_e             sz_i,
    input  op_e               op_i,
    input  logic              left_i,
    input  logic              xb_i,
    output logic [DATA_W-1:0] acc_o,
    output logic              out_o
);
    logic [4:0]        msb;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] low;
    logic [DATA_W-1:0] sh;
    logic              fill;

    always_comb begin
        unique case (sz_i)
            SZ_BYTE: msb = 5'd7;
            SZ_WORD: msb = 5'd15;
            default: msb = 5'd31;
        endcase
        mask = {DATA_W{1'b1}} >> (5'd31 - msb);
        low  = acc_i & mask;
        if (left_i) begin
            out_o = low[msb];
            unique case (op_i)
                OP_ROT:  fill = low[msb];
                OP_ROTX: fill = xb_i;
                default: fill = 1'b0;
            endcase
            sh = (low << 1) | DATA_W'(fill);
        end else begin
            out_o = low[0];
            unique case (op_i)
                OP_ARITH: fill = low[msb];
                OP_LOGIC: fill = 1'b0;
                OP_ROT:   fill = low[0];
                OP_ROTX:  fill = xb_i;
            endcase
            sh = (low >> 1) | (DATA_W'(fill) << msb);
        end
        acc_o = (sh & mask) | (acc_i & ~mask);
    end
endmodule

// File: rtl/shift_rotate_engine.sv
module shift_rotate_engine
    import sre_pkg::*;
#(
    parameter int CNT_IN_W   = 8,
    parameter int BASE_SHORT = 6,
    parameter int BASE_LONG  = 8,
    parameter int MEM_TOTAL  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                mem_i,
    input  logic [1:0]          size_i,
    input  logic [1:0]          op_i,
    input  logic                left_i,
    input  logic [CNT_IN_W-1:0] count_i,
    input  logic                x_i,
    input  logic [31:0]         operand_i,
    output logic [31:0]         result_o,
    output logic                carry_o,
    output logic                xflag_o,
    output logic                done_o,
    output logic                busy_o,
    output logic                reject_o
);
    localparam int BASE_MAX = (BASE_LONG > BASE_SHORT) ? BASE_LONG : BASE_SHORT;
    localparam int WAIT_W   = $clog2(BASE_MAX + 1);

    size_e             sz_dec, sz_q;
    op_e               op_q;
    logic              left_q;
    logic              rej_dec;
    logic [CNT_W-1:0]  steps_dec;
    logic [WAIT_W-1:0] wait_dec;
    logic              load_en, shift_en;
    logic [DATA_W-1:0] acc, acc_nxt;
    logic              cb, xb, out_bit;

    sre_req_decode #(
        .CNT_IN_W  (CNT_IN_W),
        .BASE_SHORT(BASE_SHORT),
        .BASE_LONG (BASE_LONG),
        .MEM_TOTAL (MEM_TOTAL),
        .WAIT_W    (WAIT_W)
    ) u_dec (
        .size_i  (size_i),
        .mem_i   (mem_i),
        .count_i (count_i),
        .sz_o    (sz_dec),
        .reject_o(rej_dec),
        .steps_o (steps_dec),
        .wait_o  (wait_dec)
    );

    sre_fsm #(.WAIT_W(WAIT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .reject_i(rej_dec),
        .steps_i (steps_dec),
        .wait_i  (wait_dec),
        .load_o  (load_en),
        .shift_o (shift_en),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .reject_o(reject_o)
    );

    sre_bit_step u_step (
        .acc_i (acc),
        .sz_i  (sz_q),
        .op_i  (op_q),
        .left_i(left_q),
        .xb_i  (xb),
        .acc_o (acc_nxt),
        .out_o (out_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            cb     <= 1'b0;
            xb     <= 1'b0;
            sz_q   <= SZ_BYTE;
            op_q   <= OP_ARITH;
            left_q <= 1'b0;
        end else if (load_en) begin
            acc    <= operand_i;
            cb     <= (op_e'(op_i) == OP_ROTX) ? x_i : 1'b0;
            xb     <= x_i;
            sz_q   <= sz_dec;
            op_q   <= op_e'(op_i);
            left_q <= left_i;
        end else if (shift_en) begin
            acc <= acc_nxt;
            cb  <= out_bit;
            if (op_q != OP_ROT) xb <= out_bit;
        end
    end

    assign result_o = acc;
    assign carry_o  = cb;
    assign xflag_o  = xb;

    AST_BYTE_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sz_q == SZ_BYTE) |=> (acc[31:8] == $past(acc[31:8]))); // R10
    AST_ROT_X_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_q == OP_ROT) |=> $stable(xb)); // R7
    AST_ROTX_CARRY_EQ_X: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_ROTX) |-> (cb == xb)); // R8
endmodule

// File: tb/shift_rotate_engine_tb_top.sv
module shift_rotate_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mem_i = 1'b0;
    logic [1:0]  size_i = 2'd0;
    logic [1:0]  op_i = 2'd0;
    logic        left_i = 1'b0;
    logic [7:0]  count_i = 8'd0;
    logic        x_i = 1'b0;
    logic [31:0] operand_i = 32'd0;
    logic [31:0] result_o;
    logic        carry_o, xflag_o, done_o, busy_o, reject_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    shift_rotate_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_i(mem_i),
        .size_i(size_i), .op_i(op_i), .left_i(left_i), .count_i(count_i),
        .x_i(x_i), .operand_i(operand_i), .result_o(result_o),
        .carry_o(carry_o), .xflag_o(xflag_o), .done_o(done_o),
        .busy_o(busy_o), .reject_o(reject_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] opnd, input logic [1:0] sz,
                                  input logic [1:0] op, input logic lft,
                                  input logic mem, input logic [7:0] cnt, input logic xin,
                                  output logic [31:0] res, output logic c, output logic x);
        int          top = sz[1] ? 31 : (sz[0] ? 15 : 7);
        int          n = mem ? 1 : int'(cnt % 64);
        logic [31:0] msk = (top == 31) ? 32'hFFFF_FFFF : ((32'd1 << (top + 1)) - 1);
        logic [31:0] v = opnd & msk;
        logic        o, f;
        c = (op == 2'd3) ? xin : 1'b0;
        x = xin;
        for (int i = 0; i < n; i++) begin
            if (lft) begin
                o = v[top];
                f = (op == 2'd2) ? v[top] : ((op == 2'd3) ? x : 1'b0);
                v = ((v << 1) | {31'd0, f}) & msk;
            end else begin
                o = v[0];
                case (op)
                    2'd0: f = v[top];
                    2'd1: f = 1'b0;
                    2'd2: f = v[0];
                    default: f = x;
                endcase
                v = (v >> 1) | ({31'd0, f} << top);
            end
            c = o;
            if (op != 2'd2) x = o;
        end
        res = v | (opnd & ~msk);
    endfunction

    function automatic int lat(input logic [1:0] sz, input logic mem, input logic [7:0] cnt);
        if (mem) return 8;
        return (sz[1] ? 8 : 6) + 2 * int'(cnt % 64);
    endfunction

    function automatic string optag(input logic [1:0] op, input logic lft);
        if (op == 2'd3) return "R8";
        if (op == 2'd2) return "R7";
        if (lft) return "R5";
        return "R6";
    endfunction

    // intr: 1 pokes start while busy and again in the done cycle (R12)
    task automatic run_op(input logic [31:0] opnd, input logic [1:0] sz, input logic [1:0] op,
                          input logic lft, input logic mem, input logic [7:0] cnt,
                          input logic xin, input logic intr, input string extra);
        logic [31:0] er;
        logic        ec, ex;
        int          cyc;
        int          el;
        string       ltag;
        model(opnd, sz, op, lft, mem, cnt, xin, er, ec, ex);
        el = lat(sz, mem, cnt);
        ltag = mem ? "R3" : (sz[1] ? "R2" : "R1");
        @(negedge clk);
        operand_i = opnd; size_i = sz; op_i = op; left_i = lft;
        mem_i = mem; count_i = cnt; x_i = xin; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R12", "busy after accept", {31'd0, busy_o}, 32'd1);
        cyc = 0;
        while (!done_o && cyc < 300) begin
            @(negedge clk);
            cyc++;
            if (intr && cyc == 3) begin
                operand_i = ~opnd; op_i = ~op; left_i = ~lft; count_i = cnt + 8'd3;
                start_i = 1'b1;
            end
            if (intr && cyc == 4) start_i = 1'b0;
        end
        chk(ltag, "latency", cyc, el);
        chk(optag(op, lft), {"result ", extra}, result_o, er);
        chk("R9", "carry", {31'd0, carry_o}, {31'd0, ec});
        chk("R9", "xflag", {31'd0, xflag_o}, {31'd0, ex});
        if (intr) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk("R12", "start in done cycle ignored", {31'd0, busy_o}, 32'd0);
            chk("R1", "done is one cycle", {31'd0, done_o}, 32'd0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] prev;
        void'($urandom(32'h1357_2468));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "reset busy", {31'd0, busy_o}, 32'd0);
        chk("R1", "reset done", {31'd0, done_o}, 32'd0);
        chk("R4", "reset reject", {31'd0, reject_o}, 32'd0);
        chk("R9", "reset carry", {31'd0, carry_o}, 32'd0);
        chk("R10", "reset result", result_o, 32'd0);

        // directed corners
        run_op(32'h1234_5681, 2'd0, 2'd0, 1'b1, 1'b0, 8'd1, 1'b0, 1'b0, "R5 asl byte");
        run_op(32'hFFFF_FF80, 2'd0, 2'd0, 1'b0, 1'b0, 8'd3, 1'b0, 1'b0, "R6 asr sign byte R10");
        run_op(32'h0000_8000, 2'd1, 2'd1, 1'b0, 1'b0, 8'd4, 1'b1, 1'b0, "R6 lsr word");
        run_op(32'h8000_0001, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, 1'b1, 1'b0, "R7 rol long");
        run_op(32'hAB00_0001, 2'd0, 2'd2, 1'b0, 1'b0, 8'd9, 1'b0, 1'b0, "R7 ror byte wrap");
        run_op(32'h0000_0080, 2'd0, 2'd3, 1'b1, 1'b0, 8'd9, 1'b1, 1'b0, "R8 roxl byte full circle");
        run_op(32'h0000_0001, 2'd1, 2'd3, 1'b0, 1'b0, 8'd1, 1'b0, 1'b0, "R8 roxr word");
        run_op(32'hDEAD_BEEF, 2'd1, 2'd1, 1'b1, 1'b0, 8'd0, 1'b1, 1'b0, "R9 zero count");
        run_op(32'hDEAD_BEEF, 2'd0, 2'd3, 1'b1, 1'b0, 8'd0, 1'b1, 1'b0, "R9 zero count rox");
        run_op(32'hFFFF_FFFF, 2'd3, 2'd0, 1'b1, 1'b0, 8'd63, 1'b0, 1'b0, "R2 long count 63");
        run_op(32'h0000_00F0, 2'd0, 2'd1, 1'b1, 1'b0, 8'd65, 1'b0, 1'b0, "R11 count 65 is 1");
        run_op(32'h5555_AAAA, 2'd1, 2'd0, 1'b0, 1'b1, 8'd40, 1'b0, 1'b0, "R3 memory form word");
        run_op(32'h0F0F_0F81, 2'd0, 2'd2, 1'b1, 1'b1, 8'd7, 1'b0, 1'b0, "R3 memory form byte");
        run_op(32'h7700_00C3, 2'd0, 2'd1, 1'b0, 1'b0, 8'd10, 1'b0, 1'b1, "R12 start while busy");

        // R4: long request in memory form is refused
        prev = result_o;
        @(negedge clk);
        operand_i = 32'hCAFE_F00D; size_i = 2'd2; mem_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R4", "reject pulse", {31'd0, reject_o}, 32'd1);
        chk("R4", "no busy on reject", {31'd0, busy_o}, 32'd0);
        @(negedge clk);
        chk("R4", "reject one cycle", {31'd0, reject_o}, 32'd0);
        chk("R4", "no done on reject", {31'd0, done_o}, 32'd0);
        chk("R4", "result kept", result_o, prev);
        mem_i = 1'b0;

        // constrained random
        for (int k = 0; k < 300; k++) begin
            logic [1:0] sz;
            logic       mf;
            mf = ($urandom % 6) == 0;
            sz = mf ? 2'($urandom % 2) : 2'($urandom);
            run_op($urandom, sz, 2'($urandom), 1'($urandom), mf, 8'($urandom),
                   1'($urandom), 1'b0, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule